// File: doc/BRIEF.md
# Reset Delay and Vector Fetch Sequencer

This block is the reset front end of a small 8-bit CPU core. It keeps the core stopped while any reset source is active. When a power-on reset is released, it first waits out a fixed startup delay. It then reads the two bytes of the reset vector from a mode-dependent pair of addresses and loads them into the program counter. Finally it hands the bus to the instruction fetch at that address.

There are two reset sources. The power-on indication is a synchronous, active-high level. The external reset pin is active low and passes through a two-flop synchroniser. A power-on event leaves a pending flag. That flag causes the next release to run the full startup delay, even if an external reset interrupts the delay part way. A release caused only by the external pin skips the delay and goes straight to the vector reads. A new reset from either source aborts whatever phase is running.

The mode input selects between a native vector pair and an emulation vector pair. It is captured once, on the edge that starts the vector reads.

Top module: `rstvec_sequencer`

## Requirements
- R1: While a reset source holds the block (arst_n low, pwr_on high, or the synchronised pin low), and during the startup delay, core_run and bus_rd are 0 and bus_addr shows the high-byte vector address for the live mode_emul value: 0x0FFE when mode_emul=0, 0x07FE when mode_emul=1.
- R2: After pwr_on falls, with the pin released and synchronised, bus_rd stays 0 for exactly STARTUP_CYC (4064) cycles. The high-byte read appears on the 4065th rising edge.
- R3: When the pin rises and no power-on is pending, the high-byte read appears on the third rising edge after the rise, with no startup delay.
- R4: In native mode (mode_emul=0 when the reads start), the high byte is read at 0x0FFE and the low byte at 0x0FFF, on consecutive cycles with bus_rd=1.
- R5: In emulation mode (mode_emul=1 when the reads start), the high byte is read at 0x07FE and the low byte at 0x07FF.
- R6: rd_data during the high-byte cycle becomes pc[15:8], and rd_data during the low-byte cycle becomes pc[7:0]. pc keeps its old value until the edge that ends the low-byte cycle, which loads all 16 bits and raises core_run at the same time.
- R7: Once loaded, bus_addr equals pc with bus_rd=1 and core_run=1. pc stays unchanged for as long as no reset occurs.
- R8: A reset during any phase returns the block to the hold state. A pin assertion acts on the third rising edge after the pin falls, and pwr_on acts on the next rising edge. A read sequence aborted before its low-byte edge leaves pc unchanged.
- R9: A change of mode_emul after the reads have started does not alter the addresses of that sequence.
- R10: A power-on that is still pending when an external reset interrupts the delay causes a full STARTUP_CYC delay after the pin is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous active-low block reset; it also marks a power-on as pending |
| pwr_on | input | 1 | Power-on reset indication, synchronous, active high |
| rst_pin_n | input | 1 | External reset pin, asynchronous, active low |
| mode_emul | input | 1 | Vector pair select: 0 native, 1 emulation |
| rd_data | input | 8 | Read data returned for the current bus address |
| bus_addr | output | 16 | Internal address bus |
| bus_rd | output | 1 | Read strobe for vector and opcode reads |
| pc | output | 16 | Program counter loaded from the vector |
| core_run | output | 1 | High once the vector has been loaded and the core may execute |

## Verification
Every output comes from registered state, so each result is due a fixed number of rising edges after its stimulus:
- a pwr_on change takes effect one edge later;
- a pin change takes effect three edges later, counting the two synchroniser flops and the state register;
- the end of the startup delay comes STARTUP_CYC+1 edges after pwr_on falls;
- each vector byte is captured one edge after it is presented, so pc and core_run change on the second edge after the high-byte read appears.

The bench drives inputs and samples outputs on falling edges. It counts exactly those edges before each comparison. It also checks the cycle just before each transition, to confirm that nothing moves early.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_DELAY  = 3'd1,
    ST_VEC_HI = 3'd2,
    ST_VEC_LO = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;

endpackage

// File: rtl/rvs_sync.sv
module rvs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;

  // Each flop resets to 0, i.e. reset asserted, until the pin is sampled high.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      assign d = async_i;
    end else begin : g_chain
      assign d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rvs_startup_timer.sv
module rvs_startup_timer #(
  parameter int unsigned STARTUP_CYC = 4064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic tick_i,
  output logic zero_o
);

  localparam int unsigned CNT_W   = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STARTUP_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (tick_i & (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = LOAD_VAL;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R2: the counter never leaves its loaded range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);

  // R2: a load always lands on the full count
  p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/rvs_vec_addr.sv
module rvs_vec_addr #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned NATIVE_BASE = 'h0FFE,
  parameter int unsigned EMUL_BASE   = 'h07FE
) (
  input  logic              emul_i,
  input  logic              lo_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] NAT_A = ADDR_W'(NATIVE_BASE);
  localparam logic [ADDR_W-1:0] EMU_A = ADDR_W'(EMUL_BASE);

  logic [ADDR_W-1:0] base;

  always_comb begin
    base   = emul_i ? EMU_A : NAT_A;
    addr_o = base + ADDR_W'(lo_i);
  end

endmodule

// File: rtl/rvs_fetch_ctrl.sv
module rvs_fetch_ctrl
  import rvs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              por_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              tmr_zero_i,
  output logic              tmr_load_o,
  output logic              tmr_tick_o,
  output logic              mode_q_o,
  output logic              lo_phase_o,
  output seq_state_e        state_o,
  output logic [2*DATA_W-1:0] pc_o,
  output logic              core_run_o
);

  localparam int unsigned PC_W = 2 * DATA_W;

  seq_state_e        state_q, state_d;
  logic              pend_q, pend_d;
  logic              mode_q, mode_en;
  logic [DATA_W-1:0] hi_q;
  logic              hi_en;
  logic [PC_W-1:0]   pc_q;
  logic              pc_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (hold_i) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD:   state_d = pend_q ? ST_DELAY : ST_VEC_HI;
        ST_DELAY:  state_d = tmr_zero_i ? ST_VEC_HI : ST_DELAY;
        ST_VEC_HI: state_d = ST_VEC_LO;
        ST_VEC_LO: state_d = ST_RUN;
        ST_RUN:    state_d = ST_RUN;
        default:   state_d = ST_HOLD;
      endcase
    end
  end

  // pending power-on flag and register enables
  always_comb begin
    pend_d = pend_q;
    if (por_i)                                             pend_d = 1'b1;
    else if (state_q == ST_DELAY && tmr_zero_i && !hold_i) pend_d = 1'b0;
    mode_en    = (state_d == ST_VEC_HI) && (state_q != ST_VEC_HI);
    hi_en      = (state_q == ST_VEC_HI) && !hold_i;
    pc_en      = (state_q == ST_VEC_LO) && !hold_i;
    tmr_load_o = (state_q == ST_HOLD) && !hold_i && pend_q;
    tmr_tick_o = (state_q == ST_DELAY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      pend_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= {hi_q, rdata_i};
  end

  assign mode_q_o   = mode_q;
  assign lo_phase_o = (state_q == ST_VEC_LO);
  assign state_o    = state_q;
  assign pc_o       = pc_q;
  assign core_run_o = (state_q == ST_RUN);

  // R6: core_run only rises out of the low-byte cycle
  p_load_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run_o) |-> $past(state_q) == ST_VEC_LO);

  // R7: pc holds while the core keeps running
  p_pc_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run_o && $past(core_run_o)) |-> $stable(pc_q));

  // R9: the latched mode cannot move inside a read sequence
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VEC_LO) |-> $stable(mode_q));

  // R8: power-on forces the hold state on the next edge
  p_por_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (state_q == ST_HOLD));

  // R2: the delay is only left once the timer has expired
  p_delay_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_DELAY && state_q == ST_VEC_HI) |-> $past(tmr_zero_i));

endmodule

// File: rtl/rstvec_sequencer.sv
module rstvec_sequencer
  import rvs_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned STARTUP_CYC = 4064,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NATIVE_BASE = 'h0FFE,
  parameter int unsigned EMUL_BASE   = 'h07FE
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                pwr_on,
  input  logic                rst_pin_n,
  input  logic                mode_emul,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] bus_addr,
  output logic                bus_rd,
  output logic [2*DATA_W-1:0] pc,
  output logic                core_run
);

  localparam int unsigned ADDR_W = 2 * DATA_W;

  logic              pin_sync;
  logic              hold;
  logic              tmr_load, tmr_tick, tmr_zero;
  logic              mode_q, lo_phase;
  seq_state_e        state;
  logic [ADDR_W-1:0] live_addr, fetch_addr;

  rvs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (arst_n),
    .async_i (rst_pin_n),
    .sync_o  (pin_sync)
  );

  assign hold = pwr_on | ~pin_sync;

  rvs_startup_timer #(.STARTUP_CYC(STARTUP_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (arst_n),
    .load_i (tmr_load),
    .tick_i (tmr_tick),
    .zero_o (tmr_zero)
  );

  rvs_fetch_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (arst_n),
    .hold_i     (hold),
    .por_i      (pwr_on),
    .mode_i     (mode_emul),
    .rdata_i    (rd_data),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_tick_o (tmr_tick),
    .mode_q_o   (mode_q),
    .lo_phase_o (lo_phase),
    .state_o    (state),
    .pc_o       (pc),
    .core_run_o (core_run)
  );

  rvs_vec_addr #(.ADDR_W(ADDR_W), .NATIVE_BASE(NATIVE_BASE), .EMUL_BASE(EMUL_BASE)) u_live_vec (
    .emul_i (mode_emul),
    .lo_i   (1'b0),
    .addr_o (live_addr)
  );

  rvs_vec_addr #(.ADDR_W(ADDR_W), .NATIVE_BASE(NATIVE_BASE), .EMUL_BASE(EMUL_BASE)) u_fetch_vec (
    .emul_i (mode_q),
    .lo_i   (lo_phase),
    .addr_o (fetch_addr)
  );

  always_comb begin
    unique case (state)
      ST_VEC_HI, ST_VEC_LO: begin bus_addr = fetch_addr; bus_rd = 1'b1; end
      ST_RUN:               begin bus_addr = pc;         bus_rd = 1'b1; end
      default:              begin bus_addr = live_addr;  bus_rd = 1'b0; end
    endcase
  end

  // R1: with no read in progress, the bus shows the live high-byte vector
  p_idle_addr_r1: assert property (@(posedge clk) disable iff (!arst_n)
    !bus_rd |-> (bus_addr == live_addr));

  // R7: a running core always strobes its fetch
  p_run_strobe_r7: assert property (@(posedge clk) disable iff (!arst_n)
    core_run |-> (bus_rd && bus_addr == pc));

  // R1: a synchronised pin assertion stops the core on the next edge
  p_pin_hold_r1: assert property (@(posedge clk) disable iff (!arst_n)
    !pin_sync |=> (!core_run && !bus_rd));

endmodule

// File: tb/rstvec_sequencer_tb.sv
`timescale 1ns/1ps
module rstvec_sequencer_tb;

  localparam int unsigned N = 4064;

  logic        clk = 1'b0;
  logic        arst_n, pwr_on, rst_pin_n, mode_emul;
  logic [7:0]  rd_data;
  logic [15:0] bus_addr, pc;
  logic        bus_rd, core_run;

  int n_vec = 0;
  int n_err = 0;
  logic [15:0] exp_pc = 16'h0000;

  always #2.5 clk = ~clk;

  rstvec_sequencer u_dut (
    .clk(clk), .arst_n(arst_n), .pwr_on(pwr_on), .rst_pin_n(rst_pin_n),
    .mode_emul(mode_emul), .rd_data(rd_data), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .pc(pc), .core_run(core_run)
  );

  function automatic logic [15:0] vec_addr(input logic m, input logic lo);
    return (m ? 16'h07FE : 16'h0FFE) + {15'd0, lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_hold(input string tag);
    chk({tag, " core_run"}, {31'd0, core_run}, 0);
    chk({tag, " bus_rd"},   {31'd0, bus_rd},   0);
    chk({tag, " addr"},     {16'd0, bus_addr}, {16'd0, vec_addr(mode_emul, 1'b0)});
  endtask

  // Called at the falling edge where the high-byte read is expected.
  task automatic fetch_seq(input logic m, input logic [7:0] hi, input logic [7:0] lo);
    string rq;
    rq = m ? "R5" : "R4";
    chk({rq, " hi addr"}, {16'd0, bus_addr}, {16'd0, vec_addr(m, 1'b0)});
    chk({rq, " hi rd"},   {31'd0, bus_rd}, 1);
    mode_emul = ~m;           // R9: flip mode mid-sequence
    rd_data   = hi;
    @(negedge clk);
    chk("R9 lo addr", {16'd0, bus_addr}, {16'd0, vec_addr(m, 1'b1)});
    chk("R6 pc before load", {16'd0, pc}, {16'd0, exp_pc});
    chk("R6 run before load", {31'd0, core_run}, 0);
    rd_data = lo;
    @(negedge clk);
    exp_pc = {hi, lo};
    chk("R6 pc loaded", {16'd0, pc}, {16'd0, exp_pc});
    chk("R7 core_run", {31'd0, core_run}, 1);
    chk("R7 addr=pc", {16'd0, bus_addr}, {16'd0, exp_pc});
    chk("R7 rd", {31'd0, bus_rd}, 1);
    rd_data = $urandom;
    @(negedge clk);
    chk("R7 pc stable", {16'd0, pc}, {16'd0, exp_pc});
  endtask

  // Pin reset from the running state, then release with mode m.
  task automatic pin_cycle(input int hold_len, input logic m, input logic [7:0] hi, input logic [7:0] lo);
    rst_pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 pin abort not early", {31'd0, core_run}, 1);
    @(negedge clk);
    chk_hold("R8 pin abort");
    for (int i = 0; i < hold_len; i++) begin
      mode_emul = $urandom;
      @(negedge clk);
      chk_hold("R1 hold");
    end
    mode_emul = m;
    rst_pin_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 no early read", {31'd0, bus_rd}, 0);
    @(negedge clk);
    fetch_seq(m, hi, lo);
  endtask

  task automatic wait_delay(input int pre);
    repeat (pre + N) @(negedge clk);
    chk("R2 delay not early", {31'd0, bus_rd}, 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    arst_n = 1'b0; pwr_on = 1'b1; rst_pin_n = 1'b0; mode_emul = 1'b0; rd_data = 8'h00;
    repeat (3) @(negedge clk);
    chk_hold("R1 reset native");
    mode_emul = 1'b1;
    #1;
    chk_hold("R1 reset emul");
    chk("R1 pc reset", {16'd0, pc}, 0);
    arst_n = 1'b1; rst_pin_n = 1'b1; mode_emul = 1'b0;
    repeat (4) @(negedge clk);
    chk_hold("R1 por held");

    // Power-on release: full delay, native vectors
    pwr_on = 1'b0;
    wait_delay(0);
    fetch_seq(1'b0, 8'h12, 8'h34);

    // Random pin resets without delay
    for (int k = 0; k < 40; k++) begin
      pin_cycle(int'($urandom_range(0, 4)), logic'($urandom), 8'($urandom), 8'($urandom));
    end
    pin_cycle(1, 1'b1, 8'hFF, 8'h00);
    pin_cycle(0, 1'b0, 8'h00, 8'hFF);

    // Power-on during run, pin reset during delay: delay restarts in full
    pwr_on = 1'b1;
    @(negedge clk);
    chk_hold("R8 por abort run");
    pwr_on = 1'b0;
    mode_emul = 1'b1;
    repeat (10) @(negedge clk);
    chk_hold("R1 in delay");
    rst_pin_n = 1'b0;
    repeat (4) @(negedge clk);
    chk_hold("R10 pin in delay");
    rst_pin_n = 1'b1;
    wait_delay(2);
    fetch_seq(1'b1, 8'hA5, 8'h5A);

    // Power-on during the low-byte cycle: pc not loaded
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    mode_emul = 1'b0;
    rst_pin_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 hi read", {31'd0, bus_rd}, 1);
    rd_data = 8'hC3;
    @(negedge clk);
    chk("R4 lo addr", {16'd0, bus_addr}, 16'h0FFF);
    pwr_on = 1'b1;
    rd_data = 8'h3C;
    @(negedge clk);
    chk_hold("R8 por abort lo");
    chk("R8 pc kept", {16'd0, pc}, {16'd0, exp_pc});
    pwr_on = 1'b0;
    wait_delay(0);
    fetch_seq(1'b0, 8'h0F, 8'hF0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule